// File: doc/BRIEF.md
# Dual-Bank Register File with Mid-Instruction Bank Switching

This block is the operand store of a small 8-bit processor core. It holds two banks, A and B, of sixteen 8-bit registers each, which gives 32 independent storage cells. A one-bit flag names the active bank. The core presents a decoded command, two register addresses and a data byte for two consecutive clock cycles per instruction, and marks the cycle with a phase input: 0 for the first cycle, 1 for the second. Operand reads always come from the active bank. Result writes go to the active bank. A cross-bank store puts a register copy or a byte from the core into the bank that is not active.

The bank flag is updated on the clock edge that closes the first cycle of a bank-select instruction. The second half of that instruction, and every later instruction, therefore already sees the new bank. If a read-modify-write follows a bank switch directly, it reads its operand from the new bank and writes its result back to the same new bank. Register contents change only on the edge that closes the second cycle, and at most one register changes per instruction. A flat debug bus exposes all 32 registers so that they can be observed.

Top module: `regbank_file`

## Requirements
- R1: While reset is held, and right after it is released, `active_bank` is 0 (bank A) and all 32 registers read zero.
- R2: Command code 1 (bank select) with `phase`=0 loads `active_bank` from `bank_arg` (0 = A, 1 = B) on the clock edge that ends that cycle. The new value is visible during phase 1 of the same instruction.
- R3: `active_bank` keeps its value on every edge except one that ends phase 0 of a bank-select command. A bank-select command presented only during phase 1 has no effect.
- R4: `rd_x` and `rd_y` show, without a clock delay, registers `addr_x` and `addr_y` of the active bank. The instruction that directly follows a bank switch reads the newly selected bank.
- R5: Command code 2 (write) with `phase`=1 stores `wr_data` into register `addr_x` of the active bank on the edge that ends that cycle. A read-modify-write placed right after a bank switch takes its source from the new bank and updates the new bank.
- R6: No register changes on an edge that ends phase 0, whatever the command. During phase 1, command codes 0 (no operation), 1 and 5 to 7 change no register.
- R7: Command code 3 (cross copy) with `phase`=1 copies register `addr_y` of the active bank into register `addr_x` of the other bank. The active bank is left untouched.
- R8: Command code 4 (cross constant) with `phase`=1 writes `wr_data` into register `addr_x` of the inactive bank. The active bank is left untouched.
- R9: `dbg_regs` carries register r of bank b at bits [(b*16 + r)*8 +: 8]. Bank A is b=0 and bank B is b=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| phase | input | 1 | Instruction cycle: 0 = first, 1 = second |
| cmd | input | 3 | Decoded command code |
| bank_arg | input | 1 | Target bank of a bank-select command |
| addr_x | input | 4 | Destination / first operand register index |
| addr_y | input | 4 | Second operand register index |
| wr_data | input | 8 | Result byte or constant to store |
| rd_x | output | 8 | Active-bank register `addr_x` |
| rd_y | output | 8 | Active-bank register `addr_y` |
| active_bank | output | 1 | Current bank flag (0 = A, 1 = B) |
| dbg_regs | output | 256 | All 32 registers, flattened |

## Verification
The bench builds the block with its default parameters: 8-bit data and sixteen registers per bank. At this size a fully loaded register file of 32 distinct values can be compared against a model after every instruction. Directed sequences place a read-modify-write right behind a bank switch in both directions, issue a bank select and a write in the wrong phase, and send cross-bank stores from each bank. A seeded random stream then mixes all eight command codes, in either phase and on any addresses.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
    typedef enum logic [2:0] {
        CMD_NOP   = 3'd0,
        CMD_BANK  = 3'd1,
        CMD_WRITE = 3'd2,
        CMD_XREG  = 3'd3,
        CMD_XIMM  = 3'd4
    } rb_cmd_e;

    typedef struct packed {
        logic bank;
    } rb_ctrl_s;
endpackage

// File: rtl/regbank_ctrl.sv
// Bank flag and write-port decode.
module regbank_ctrl
    import regbank_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int AW     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              phase,
    input  logic [2:0]        cmd,
    input  logic              bank_arg,
    input  logic [AW-1:0]     addr_x,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [DATA_W-1:0] y_val,
    output logic              bank,
    output logic              we,
    output logic              wbank,
    output logic [AW-1:0]     waddr,
    output logic [DATA_W-1:0] wdata
);
    rb_ctrl_s state_d, state_q;
    rb_cmd_e  cmd_e;

    assign cmd_e = rb_cmd_e'(cmd);

    always_comb begin
        state_d = state_q;
        // The flag moves at the end of the first cycle of a bank select.
        if (!phase && cmd_e == CMD_BANK) begin
            state_d.bank = bank_arg;
        end
    end

    always_comb begin
        we    = 1'b0;
        wbank = state_q.bank;
        waddr = addr_x;
        wdata = wr_data;
        if (phase) begin
            case (cmd_e)
                CMD_WRITE: we = 1'b1;
                CMD_XREG: begin
                    we    = 1'b1;
                    wbank = ~state_q.bank;
                    wdata = y_val;
                end
                CMD_XIMM: begin
                    we    = 1'b1;
                    wbank = ~state_q.bank;
                end
                default: we = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign bank = state_q.bank;
endmodule

// File: rtl/regbank_storage.sv
// Two banks of registers, one write port, two read ports.
// NUM_REGS must be a power of two.
module regbank_storage #(
    parameter int DATA_W   = 8,
    parameter int NUM_REGS = 16
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                we,
    input  logic                                wbank,
    input  logic [$clog2(NUM_REGS)-1:0]         waddr,
    input  logic [DATA_W-1:0]                   wdata,
    input  logic                                rbank,
    input  logic [$clog2(NUM_REGS)-1:0]         raddr_x,
    input  logic [$clog2(NUM_REGS)-1:0]         raddr_y,
    output logic [DATA_W-1:0]                   rdata_x,
    output logic [DATA_W-1:0]                   rdata_y,
    output logic [2*NUM_REGS*DATA_W-1:0]        dump
);
    localparam int NUM_BANKS = 2;
    localparam int AW        = $clog2(NUM_REGS);
    localparam int IDX_W     = AW + 1;
    localparam int CELLS     = NUM_BANKS * NUM_REGS;

    logic [DATA_W-1:0] words [CELLS];
    logic [IDX_W-1:0]  widx;

    assign widx = {wbank, waddr};

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        for (genvar r = 0; r < NUM_REGS; r++) begin : g_cell
            localparam int              IDX = b * NUM_REGS + r;
            localparam logic [IDX_W-1:0] ID = IDX_W'(IDX);
            logic [DATA_W-1:0] cell_d, cell_q;

            always_comb begin
                cell_d = cell_q;
                if (we && widx == ID) begin
                    cell_d = wdata;
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cell_q <= '0;
                end else begin
                    cell_q <= cell_d;
                end
            end

            assign words[IDX]                  = cell_q;
            assign dump[IDX*DATA_W +: DATA_W]  = cell_q;
        end
    end

    assign rdata_x = words[{rbank, raddr_x}];
    assign rdata_y = words[{rbank, raddr_y}];
endmodule

// File: rtl/regbank_file.sv
module regbank_file #(
    parameter int DATA_W   = 8,
    parameter int NUM_REGS = 16
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             phase,
    input  logic [2:0]                       cmd,
    input  logic                             bank_arg,
    input  logic [$clog2(NUM_REGS)-1:0]      addr_x,
    input  logic [$clog2(NUM_REGS)-1:0]      addr_y,
    input  logic [DATA_W-1:0]                wr_data,
    output logic [DATA_W-1:0]                rd_x,
    output logic [DATA_W-1:0]                rd_y,
    output logic                             active_bank,
    output logic [2*NUM_REGS*DATA_W-1:0]     dbg_regs
);
    localparam int AW = $clog2(NUM_REGS);

    logic              we, wbank;
    logic [AW-1:0]     waddr;
    logic [DATA_W-1:0] wdata;

    regbank_ctrl #(.DATA_W(DATA_W), .AW(AW)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .phase   (phase),
        .cmd     (cmd),
        .bank_arg(bank_arg),
        .addr_x  (addr_x),
        .wr_data (wr_data),
        .y_val   (rd_y),
        .bank    (active_bank),
        .we      (we),
        .wbank   (wbank),
        .waddr   (waddr),
        .wdata   (wdata)
    );

    regbank_storage #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (we),
        .wbank  (wbank),
        .waddr  (waddr),
        .wdata  (wdata),
        .rbank  (active_bank),
        .raddr_x(addr_x),
        .raddr_y(addr_y),
        .rdata_x(rd_x),
        .rdata_y(rd_y),
        .dump   (dbg_regs)
    );
endmodule

// File: rtl/regbank_file_chk.sv
module regbank_file_chk #(
    parameter int DATA_W   = 8,
    parameter int NUM_REGS = 16
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic                             phase,
    input logic [2:0]                       cmd,
    input logic                             bank_arg,
    input logic [DATA_W-1:0]                rd_x,
    input logic                             active_bank,
    input logic [2*NUM_REGS*DATA_W-1:0]     dbg_regs
);
    localparam int HALF = NUM_REGS * DATA_W;

    logic bank_cmd0, quiet1, cross1;
    assign bank_cmd0 = !phase && cmd == 3'd1;
    assign quiet1    = phase && !(cmd == 3'd2 || cmd == 3'd3 || cmd == 3'd4);
    assign cross1    = phase && (cmd == 3'd3 || cmd == 3'd4);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (active_bank == 1'b0 && dbg_regs == '0));

    // R2
    bank_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bank_cmd0 |=> active_bank == $past(bank_arg));

    // R3
    bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bank_cmd0 |=> $stable(active_bank));

    // R6
    phase0_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !phase |=> $stable(dbg_regs));

    // R6
    nowrite_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        quiet1 |=> $stable(dbg_regs));

    // R7
    cross_a_safe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cross1 && !active_bank) |=> $stable(dbg_regs[HALF-1:0]));

    // R8
    cross_b_safe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cross1 && active_bank) |=> $stable(dbg_regs[2*HALF-1:HALF]));
endmodule

bind regbank_file regbank_file_chk #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .phase      (phase),
    .cmd        (cmd),
    .bank_arg   (bank_arg),
    .rd_x       (rd_x),
    .active_bank(active_bank),
    .dbg_regs   (dbg_regs)
);

// File: tb/regbank_file_test.sv
`timescale 1ns/1ps
module regbank_file_test;
    localparam int DW = 8;
    localparam int NR = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          phase = 1'b0;
    logic [2:0]    cmd = 3'd0;
    logic          bank_arg = 1'b0;
    logic [3:0]    addr_x = '0, addr_y = '0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_x, rd_y;
    logic          active_bank;
    logic [2*NR*DW-1:0] dbg_regs;

    int   vectors = 0;
    int   errors  = 0;
    bit   done    = 0;

    logic [DW-1:0] mem [2][NR];
    logic          mbank;

    regbank_file #(.DATA_W(DW), .NUM_REGS(NR)) uut (
        .clk(clk), .rst_n(rst_n), .phase(phase), .cmd(cmd), .bank_arg(bank_arg),
        .addr_x(addr_x), .addr_y(addr_y), .wr_data(wr_data),
        .rd_x(rd_x), .rd_y(rd_y), .active_bank(active_bank), .dbg_regs(dbg_regs)
    );

    always #10 clk = ~clk;

    function automatic logic [2*NR*DW-1:0] exp_flat();
        logic [2*NR*DW-1:0] v;
        for (int b = 0; b < 2; b++)
            for (int r = 0; r < NR; r++)
                v[(b*NR + r)*DW +: DW] = mem[b][r];
        return v;
    endfunction

    task automatic check(input string req, input logic [2*NR*DW-1:0] act, input logic [2*NR*DW-1:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_state(input string req);
        check({req, " bank"}, {{(2*NR*DW-1){1'b0}}, active_bank}, {{(2*NR*DW-1){1'b0}}, mbank});
        check({req, " regs"}, dbg_regs, exp_flat());
    endtask

    // One two-cycle instruction; c0 is presented in phase 0, c1 in phase 1.
    task automatic instr(input logic [2:0] c0, input logic [2:0] c1, input logic b,
                         input logic [3:0] x, input logic [3:0] y, input logic [DW-1:0] d,
                         input bit rmw, input logic [DW-1:0] k, input string req);
        logic [DW-1:0] dv;
        @(negedge clk);
        phase = 1'b0; cmd = c0; bank_arg = b; addr_x = x; addr_y = y; wr_data = d;
        @(negedge clk);
        if (c0 == 3'd1) mbank = b;
        phase = 1'b1; cmd = c1;
        dv = d;
        #1;
        // R4 operands come from the bank chosen in the first half
        check({req, " R4 rd_x"}, {{(2*NR*DW-DW){1'b0}}, rd_x}, {{(2*NR*DW-DW){1'b0}}, mem[mbank][x]});
        check({req, " R4 rd_y"}, {{(2*NR*DW-DW){1'b0}}, rd_y}, {{(2*NR*DW-DW){1'b0}}, mem[mbank][y]});
        if (rmw) begin
            wr_data = rd_x & k;
            dv      = mem[mbank][x] & k;
        end
        @(posedge clk);
        case (c1)
            3'd2: mem[mbank][x]  = dv;
            3'd3: mem[~mbank][x] = mem[mbank][y];
            3'd4: mem[~mbank][x] = dv;
            default: ;
        endcase
        #5;
        check_state(req);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        for (int b = 0; b < 2; b++)
            for (int r = 0; r < NR; r++)
                mem[b][r] = '0;
        mbank = 1'b0;
        repeat (3) @(posedge clk);
        #5;
        check_state("R1 reset R9");
        @(negedge clk);
        rst_n = 1'b1;
        #2;
        check_state("R1 after release");

        // Fill bank A, switch to B, fill bank B with distinct values (R5 R9)
        for (int r = 0; r < NR; r++)
            instr(3'd0, 3'd2, 1'b0, 4'(r), 4'(r), 8'h10 + 8'(r), 0, 8'h00, "R5 fill A");
        instr(3'd1, 3'd0, 1'b1, 4'd0, 4'd1, 8'h00, 0, 8'h00, "R2 select B");
        for (int r = 0; r < NR; r++)
            instr(3'd0, 3'd2, 1'b0, 4'(r), 4'(r), 8'hA0 + 8'(r), 0, 8'h00, "R5 fill B");

        // Switch to A then immediate read-modify-write (R2 R5)
        instr(3'd1, 3'd0, 1'b0, 4'd0, 4'd0, 8'h00, 0, 8'h00, "R2 select A");
        instr(3'd0, 3'd2, 1'b0, 4'd0, 4'd0, 8'h00, 1, 8'h07, "R5 rmw after switch to A");
        instr(3'd1, 3'd0, 1'b1, 4'd2, 4'd3, 8'h00, 0, 8'h00, "R2 select B again");
        instr(3'd0, 3'd2, 1'b0, 4'd2, 4'd2, 8'h00, 1, 8'h3C, "R5 rmw after switch to B");

        // Bank select only in phase 1 is ignored (R3)
        instr(3'd0, 3'd1, 1'b0, 4'd4, 4'd5, 8'h00, 0, 8'h00, "R3 late bank select");
        // Write only in phase 0 is ignored (R6)
        instr(3'd2, 3'd0, 1'b0, 4'd6, 4'd7, 8'hEE, 0, 8'h00, "R6 early write");
        instr(3'd0, 3'd7, 1'b0, 4'd6, 4'd7, 8'hEE, 0, 8'h00, "R6 unused code");

        // Cross-bank stores from B (R7 R8)
        instr(3'd0, 3'd3, 1'b0, 4'd3, 4'd5, 8'h00, 0, 8'h00, "R7 copy B to A");
        instr(3'd0, 3'd4, 1'b0, 4'd15, 4'd0, 8'h5A, 0, 8'h00, "R8 const to A");
        // Cross-bank stores from A
        instr(3'd1, 3'd0, 1'b0, 4'd0, 4'd0, 8'h00, 0, 8'h00, "R2 select A");
        instr(3'd0, 3'd3, 1'b0, 4'd9, 4'd15, 8'h00, 0, 8'h00, "R7 copy A to B");
        instr(3'd0, 3'd4, 1'b0, 4'd0, 4'd0, 8'hC3, 0, 8'h00, "R8 const to B");

        // Random mix
        for (int i = 0; i < 600; i++) begin
            logic [2:0] c0, c1;
            c0 = ($urandom % 3 == 0) ? 3'd1 : 3'($urandom % 8);
            c1 = 3'($urandom % 8);
            instr(c0, c1, 1'($urandom), 4'($urandom), 4'($urandom), 8'($urandom),
                  ($urandom % 4) == 0, 8'($urandom), "R2 R3 R5 R6 R7 R8 random");
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule